// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a two-wire serial slave engine in a byte-wide nonvolatile memory. A write command loads a start address. Data bytes then land in a page latch of `PAGE` entries. The page base is fixed by the upper address bits. The in-page offset advances and wraps inside that page. When the engine signals that a stop condition has ended the command, the block samples the write-protect input. If the latch holds at least one byte and protection is off, it starts a self-timed commit cycle.

The commit has three phases and always rewrites the whole page:

- FILL reads every page location from the array. Locations the command did not write are loaded into the latch with their old contents.
- PROG writes the latch back to the array, one byte per clock, at ascending offsets.
- HOLD waits out the rest of the programmable cycle time.

`busy` stays high for exactly `CYCLE_CLKS` clocks. While `busy` is high the block ignores new commands.

The states are IDLE, COLLECT, FILL, PROG and HOLD. The transitions are:

- IDLE→COLLECT on an address load.
- COLLECT→COLLECT on a data byte or on a reloaded address.
- COLLECT→FILL on a stop that has data and no protection.
- COLLECT→IDLE on a stop that is protected or carries no data.
- FILL→PROG after the last read returns.
- PROG→HOLD after the last offset is written.
- HOLD→IDLE when the cycle timer expires.

Top module: `page_write_commit`

## Requirements
- R1: Data byte k of a command is stored at offset (start offset + k) mod PAGE. The start offset is the low 7 address bits. Byte k lands in the page whose base is the start address with its low 7 bits cleared; it never moves into the next page.
- R2: When more than PAGE bytes are sent in one command, a later byte replaces an earlier one at the same offset.
- R3: A stop (`stop_pulse` high for one clock in COLLECT) starts a commit when at least one byte arrived and `wp` is low. `busy` rises on the clock after the stop and stays high for exactly CYCLE_CLKS clocks.
- R4: During the commit the array sees exactly PAGE write strobes (`arr_we`). They fall on consecutive clocks at offsets 0,1,...,PAGE-1 of the page.
- R5: A page location not written by the command is rewritten with the value the array held before the commit.
- R6: When `wp` is high at the stop, `busy` never rises and the array receives no write. A new command is accepted at once.
- R7: Changing `wp` while `busy` is high does not alter or shorten the commit.
- R8: A stop that ends a command which only loaded an address starts no commit.
- R9: `addr_load`, `byte_valid` and `stop_pulse` have no effect while `busy` is high.
- R10: After reset, `busy`, `arr_we` and `arr_re` are low.
- R11: No clock carries both `arr_re` and `arr_we`. During a commit `arr_addr` stays inside one page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe: begin a write command at `addr_in` |
| addr_in | input | 17 | Start byte address of the command |
| byte_valid | input | 1 | Strobe: `byte_data` carries a data byte |
| byte_data | input | 8 | Data byte from the slave engine |
| stop_pulse | input | 1 | Strobe: stop condition ended the command |
| wp | input | 1 | Write protect, sampled only with the stop |
| arr_addr | output | 17 | Array byte address |
| arr_re | output | 1 | Array read strobe; data returns next clock |
| arr_we | output | 1 | Array write strobe |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, one clock after `arr_re` |
| busy | output | 1 | Commit cycle in progress |

## Verification
The bench aims at these failure modes:

- **Page wrap.** A start near the top of the last page would, if the carry leaked out of the offset, send bytes into a page that does not exist or into the page below.
- **Overrun.** A run of more than a page of bytes would keep the oldest bytes instead of the newest if replacement were broken.
- **Refresh.** A single-byte write must put the prior array contents back in the other 127 locations. A design that skipped the refresh would write stale latch data, which the scoreboard sees on every unwritten offset.
- **Protect and ignore cases.** These include protection at the stop, a protect toggle during the cycle, an address-only command, and traffic injected while busy. A design that sampled `wp` late, treated an empty latch as data, or accepted input while busy would show a wrong busy length or an unexpected array write.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_FILL,
        ST_PROG,
        ST_HOLD
    } pgc_state_e;
endpackage

// File: rtl/pgc_latch.sv
module pgc_latch #(
    parameter int PAGE = 128,
    parameter int DW   = 8,
    localparam int OW  = $clog2(PAGE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            mark,
    input  logic            clr,
    input  logic [OW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [OW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic [PAGE-1:0] mask,
    output logic            any
);
    logic [DW-1:0]   store [PAGE];
    logic [PAGE-1:0] hit;

    // one decoder per entry: marks bytes the bus command wrote
    for (genvar g = 0; g < PAGE; g++) begin : g_hit
        assign hit[g] = wr_en && mark && (wr_idx == OW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mask <= '0;
        else if (clr)  mask <= '0;
        else           mask <= mask | hit;
    end

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    assign rd_data = store[rd_idx];
    assign any     = |mask;
endmodule

// File: rtl/pgc_timer.sv
module pgc_timer #(
    parameter int CYCLES = 300,
    localparam int TW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= TW'(CYCLES - 1);
        else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit
    import pgc_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DW         = 8,
    parameter int PAGE       = 128,
    parameter int CYCLE_CLKS = 300   // must be at least 2*PAGE+2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DW-1:0]     byte_data,
    input  logic              stop_pulse,
    input  logic              wp,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_re,
    output logic              arr_we,
    output logic [DW-1:0]     arr_wdata,
    input  logic [DW-1:0]     arr_rdata,
    output logic              busy
);
    localparam int OW = $clog2(PAGE);
    localparam int PW = ADDR_W - OW;
    localparam int CW = $clog2(PAGE + 1);
    localparam logic [CW-1:0] CNT_END  = CW'(PAGE);
    localparam logic [CW-1:0] CNT_LAST = CW'(PAGE - 1);

    pgc_state_e state_q, state_d;
    logic [PW-1:0] page_q;
    logic [OW-1:0] ptr_q;
    logic [CW-1:0] cnt_q;

    logic            lat_we, lat_mark, lat_clr, lat_any;
    logic [OW-1:0]   lat_widx;
    logic [DW-1:0]   lat_wdata, lat_rdata;
    logic [PAGE-1:0] lat_mask;
    logic            tmr_load, tmr_zero;

    logic          in_cmd, take_load, take_byte, commit_go;
    logic [OW-1:0] fill_idx;

    assign in_cmd    = (state_q == ST_IDLE) || (state_q == ST_COLLECT);
    assign take_load = in_cmd && addr_load && !stop_pulse;
    assign take_byte = (state_q == ST_COLLECT) && byte_valid && !stop_pulse && !addr_load;
    assign commit_go = (state_q == ST_COLLECT) && stop_pulse && lat_any && !wp;
    assign fill_idx  = OW'(cnt_q - 1'b1);

    pgc_latch #(.PAGE(PAGE), .DW(DW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lat_we),
        .mark    (lat_mark),
        .clr     (lat_clr),
        .wr_idx  (lat_widx),
        .wr_data (lat_wdata),
        .rd_idx  (cnt_q[OW-1:0]),
        .rd_data (lat_rdata),
        .mask    (lat_mask),
        .any     (lat_any)
    );

    pgc_timer #(.CYCLES(CYCLE_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (busy),
        .zero  (tmr_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_load) state_d = ST_COLLECT;
            ST_COLLECT: if (stop_pulse) state_d = commit_go ? ST_FILL : ST_IDLE;
            ST_FILL:    if (cnt_q == CNT_END) state_d = ST_PROG;
            ST_PROG:    if (cnt_q == CNT_LAST) state_d = ST_HOLD;
            ST_HOLD:    if (tmr_zero) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // page base, in-page pointer and sweep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (take_load) begin
                page_q <= addr_in[ADDR_W-1:OW];
                ptr_q  <= addr_in[OW-1:0];
            end else if (take_byte) begin
                ptr_q  <= ptr_q + 1'b1;   // wraps inside the page
            end
            if (commit_go)                      cnt_q <= '0;
            else if (state_q == ST_FILL)        cnt_q <= (cnt_q == CNT_END) ? '0 : cnt_q + 1'b1;
            else if (state_q == ST_PROG)        cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs and latch control
    always_comb begin
        busy      = 1'b0;
        arr_re    = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = {page_q, cnt_q[OW-1:0]};
        arr_wdata = lat_rdata;
        lat_we    = take_byte;
        lat_mark  = 1'b1;
        lat_widx  = ptr_q;
        lat_wdata = byte_data;
        lat_clr   = take_load
                 || ((state_q == ST_COLLECT) && stop_pulse && !commit_go)
                 || ((state_q == ST_HOLD) && tmr_zero);
        tmr_load  = commit_go;
        unique case (state_q)
            ST_FILL: begin
                busy   = 1'b1;
                arr_re = (cnt_q != CNT_END);
                if (cnt_q != '0 && !lat_mask[fill_idx]) begin
                    lat_we    = 1'b1;
                    lat_mark  = 1'b0;
                    lat_widx  = fill_idx;
                    lat_wdata = arr_rdata;
                end
            end
            ST_PROG: begin
                busy   = 1'b1;
                arr_we = 1'b1;
            end
            ST_HOLD:    busy = 1'b1;
            ST_IDLE:    ;
            ST_COLLECT: ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
    parameter int ADDR_W = 17,
    parameter int OW     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_pulse,
    input logic              wp,
    input logic              busy,
    input logic              arr_we,
    input logic              arr_re,
    input logic [ADDR_W-1:0] arr_addr
);
    p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_we_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(arr_we) |-> arr_addr[OW-1:0] == OW'($past(arr_addr[OW-1:0]) + 1'b1));

    p_start_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_pulse) && !$past(wp));

    p_no_rw_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_we && arr_re));

    p_one_page_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(arr_addr[ADDR_W-1:OW]));
endmodule

bind page_write_commit pgc_checker #(.ADDR_W(ADDR_W), .OW($clog2(PAGE))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_pulse (stop_pulse),
    .wp         (wp),
    .busy       (busy),
    .arr_we     (arr_we),
    .arr_re     (arr_re),
    .arr_addr   (arr_addr)
);

// File: tb/sim_page_write_commit.sv
module sim_page_write_commit;
    localparam int CYC = 300;

    logic        clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [16:0] addr_in = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_pulse = 1'b0;
    logic        wp = 1'b0;
    logic [16:0] arr_addr;
    logic        arr_re, arr_we, busy;
    logic [7:0]  arr_wdata;
    logic [7:0]  arr_rdata = '0;

    int checks = 0;
    int bad    = 0;
    int cur_page = 0;

    typedef struct { int a; logic [7:0] d; } item_t;
    item_t q[$];
    logic [7:0] mem [int];

    page_write_commit #(.CYCLE_CLKS(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_pulse(stop_pulse),
        .wp(wp), .arr_addr(arr_addr), .arr_re(arr_re), .arr_we(arr_we),
        .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .busy(busy)
    );

    function automatic logic [7:0] seed_val(int a);
        return 8'(a ^ (a >> 8) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] model_rd(int a);
        if (mem.exists(a)) return mem[a];
        return seed_val(a);
    endfunction

    // array model: read data one clock after the strobe
    always @(posedge clk) begin
        if (arr_re) arr_rdata <= model_rd(int'(arr_addr));
        if (arr_we) mem[int'(arr_addr)] = arr_wdata;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pop on every array write
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (arr_we === 1'b1 || arr_re === 1'b1)
                chk(!(arr_we && arr_re) && (int'(arr_addr) >> 7) == cur_page,
                    "R11 strobe/page", int'(arr_addr), cur_page << 7);
            if (arr_we === 1'b1) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected array write", int'(arr_addr), -1);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    chk(int'(arr_addr) == it.a && arr_wdata == it.d,
                        "R4 R1 R5 write addr/data",
                        (int'(arr_addr) << 8) | int'(arr_wdata),
                        (it.a << 8) | int'(it.d));
                end
            end
        end
    end

    task automatic do_load(input int a);
        @(negedge clk); addr_load = 1'b1; addr_in = a[16:0];
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_data = d;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
    endtask

    // driver: builds the expected page and queues it
    task automatic run_write(input int a, input int n, input logic wpv, input logic [7:0] seed);
        logic [7:0] pg [128];
        bit         wr [128];
        int base;
        int off;
        base = a & ~127;
        off  = a & 127;
        cur_page = a >> 7;
        for (int k = 0; k < 128; k++) begin wr[k] = 1'b0; pg[k] = '0; end
        do_load(a);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'(int'(seed) + k);
            do_byte(d);
            pg[(off + k) & 127] = d;
            wr[(off + k) & 127] = 1'b1;
        end
        if (n > 0 && !wpv)
            for (int k = 0; k < 128; k++)
                q.push_back('{base + k, wr[k] ? pg[k] : model_rd(base + k)});
        wp = wpv;
        do_stop();
    endtask

    task automatic measure(input int exp_n, input bit tog, input bit inj, input string tag);
        int n;
        n = 0;
        while (busy === 1'b1 && n < CYC + 50) begin
            if (tog && n == 10) wp = ~wp;
            addr_load  = inj && (n == 20);
            addr_in    = 17'h00605;
            byte_valid = inj && (n == 22);
            byte_data  = 8'hEE;
            n++;
            @(negedge clk);
        end
        addr_load  = 1'b0;
        byte_valid = 1'b0;
        chk(n == exp_n, tag, n, exp_n);
        chk(q.size() == 0, "R4 pending writes", q.size(), 0);
        wp = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL R3 watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0,   "R10 busy after reset", busy, 0);
        chk(arr_we == 1'b0, "R10 arr_we after reset", arr_we, 0);
        chk(arr_re == 1'b0, "R10 arr_re after reset", arr_re, 0);

        // R3 R5: single byte, rest of page refreshed
        run_write(32'h00123, 1, 1'b0, 8'hA0);
        measure(CYC, 1'b0, 1'b0, "R3 busy length single byte");

        // R1: wrap at top of last page
        run_write(32'h1FFFD, 5, 1'b0, 8'h10);
        measure(CYC, 1'b0, 1'b0, "R1 busy length wrap");

        // R2: overrun replaces the oldest bytes
        run_write(32'h00200, 130, 1'b0, 8'h40);
        measure(CYC, 1'b0, 1'b0, "R2 busy length overrun");

        // full page
        run_write(32'h00380, 128, 1'b0, 8'hC0);
        measure(CYC, 1'b0, 1'b0, "R4 busy length full page");

        // R6: protected at stop, then an immediate new command
        run_write(32'h00123, 3, 1'b1, 8'h77);
        measure(0, 1'b0, 1'b0, "R6 busy under protect");
        chk(model_rd(32'h123) == 8'hA0, "R6 array unchanged", model_rd(32'h123), 8'hA0);
        chk(model_rd(32'h124) == seed_val(32'h124), "R6 array unchanged",
            model_rd(32'h124), seed_val(32'h124));

        // R7: protect toggled during the cycle
        run_write(32'h00050, 2, 1'b0, 8'h33);
        measure(CYC, 1'b1, 1'b0, "R7 busy length with wp toggle");
        chk(model_rd(32'h51) == 8'h34, "R7 data committed", model_rd(32'h51), 8'h34);

        // R8: address-only command
        do_load(32'h00400);
        wp = 1'b0;
        do_stop();
        measure(0, 1'b0, 1'b0, "R8 busy after address-only");

        // R9: traffic while busy is ignored
        run_write(32'h00600, 1, 1'b0, 8'h99);
        measure(CYC, 1'b0, 1'b1, "R9 busy length with injected traffic");
        do_stop();
        measure(0, 1'b0, 1'b0, "R9 stop after ignored traffic");
        chk(model_rd(32'h605) == seed_val(32'h605), "R9 injected byte not stored",
            model_rd(32'h605), seed_val(32'h605));

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule